// File: doc/BRIEF.md
# DMA Descriptor Chain Loader

This block handles the link phase of a single DMA channel. Each time the data engine signals that a transfer has finished, the block inspects the channel's link word. From that word it decides whether the descriptor chain is over. If the chain goes on, it fetches the next descriptor from memory, one 32-bit word at a time, and loads it into the channel's register set. The register set holds two transfer-configuration words, a block-count word, a source address, a destination address and the link word itself.

A 16-bit word pointer and six per-register reload flags sit in the link word. A descriptor holds one word for each flagged register and nothing for the others. When the block-count word is not reloaded, its count field returns to its reload value so that the next block runs the same length. Software preloads the registers and a fixed upper address half through a plain write strobe. The data engine decrements the count while it moves data.

The memory side is a read request channel with valid/ready and a response strobe with an error bit. Back-pressure rules: once `rd_req_valid_o` is high, it stays high and `rd_req_addr_o` holds its value until the cycle in which `rd_req_ready_i` is high. Only one request is outstanding at a time. The response channel has no ready, so the block always accepts a response while it waits for one.

Top module: `dma_link_loader`

## Requirements
- R1: After reset all channel registers, the upper base and the reload value are zero, and `busy_o`, `rd_req_valid_o`, `desc_loaded_o`, `chan_done_o` and `link_err_o` are low.
- R2: Bits [1:0] of the link register always read as zero, whatever value is written into it by software or by a fetch.
- R3: When the link word has flags [21:16] all zero and pointer bits [15:2] all zero, a sampled `xfer_done_i` gives a one-cycle `chan_done_o` in the next cycle. No memory request is issued and no register changes.
- R4: Fetch addresses are the upper base (written with select code 6, low 16 bits used) concatenated with the link word's bits [15:2] and two zero bits. Words are fetched in the order config 1, config 2, block count, source, destination, link word, selected by flag bits 16 to 21 in that order. Unflagged entries are skipped, and the address rises by 4 for each word fetched.
- R5: Each response word overwrites only the register it was fetched for. Registers with a clear flag keep their values. Software write select codes are 0 config 1, 1 config 2, 2 block count, 3 source, 4 destination, 5 link.
- R6: If the block-count flag (bit 18) is clear and the chain goes on, the count field [15:0] is set to the reload value in the cycle after `xfer_done_i` is sampled, before any fetch. The reload value is the count last written by software or fetched from memory. At end of chain the count is left as it is.
- R7: If the restore and a `blk_dec_i` decrement fall in the same cycle, the restore wins and the count equals the reload value.
- R8: Flags and pointer are captured when the link phase starts. A link word fetched during a phase governs only the next phase.
- R9: A response with `rd_rsp_err_i` high ends the phase at once. `link_err_o` rises and stays high until reset, no further request is made, no `desc_loaded_o` pulse follows, and the block returns to idle.
- R10: `desc_loaded_o` pulses for one cycle after the last response of a phase. With no flags set and a non-null pointer, it pulses in the cycle after `xfer_done_i` and nothing is fetched. It is never high together with `chan_done_o`.
- R11: `xfer_done_i` is ignored while `busy_o` is high.
- R12: A request that is not accepted keeps `rd_req_valid_o` high and `rd_req_addr_o` unchanged until `rd_req_ready_i` is high.
- R13: While idle, `blk_dec_i` lowers the count field [15:0] by one and leaves it at zero once it reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en_i | input | 1 | Software register write strobe |
| sw_wr_sel_i | input | 3 | Register select for the software write |
| sw_wr_data_i | input | 32 | Software write data |
| xfer_done_i | input | 1 | Data transfer finished, starts the link phase |
| blk_dec_i | input | 1 | Decrement the block-count field |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | 32 | Read request word address |
| rd_rsp_valid_i | input | 1 | Read response strobe |
| rd_rsp_data_i | input | 32 | Read response data |
| rd_rsp_err_i | input | 1 | Read response error |
| cfg1_o | output | 32 | Transfer configuration word 1 |
| cfg2_o | output | 32 | Transfer configuration word 2 |
| blk_o | output | 32 | Block-count word |
| src_o | output | 32 | Source address |
| dst_o | output | 32 | Destination address |
| link_o | output | 32 | Link word |
| busy_o | output | 1 | Link phase in progress |
| desc_loaded_o | output | 1 | Descriptor load finished pulse |
| chan_done_o | output | 1 | End-of-chain pulse |
| link_err_o | output | 1 | Sticky fetch error flag |

## Verification
The count restore and a data-engine decrement can land on the same clock edge. The bench provokes this by raising `xfer_done_i` and `blk_dec_i` in the same cycle. The link word it uses has a null flag set and a non-null pointer, and the count is first lowered below its reload value. The bench then expects the full reload value on the next cycle, together with a `desc_loaded_o` pulse and no memory request. A separate decrement while idle confirms that the decrement path works on its own, so the priority result is not an artefact of a dead input.

// File: rtl/dll_pkg.sv
package dll_pkg;
  localparam int unsigned NREG     = 6;
  localparam int unsigned IDX_CFG1 = 0;
  localparam int unsigned IDX_CFG2 = 1;
  localparam int unsigned IDX_BLK  = 2;
  localparam int unsigned IDX_SRC  = 3;
  localparam int unsigned IDX_DST  = 4;
  localparam int unsigned IDX_LINK = 5;
  localparam int unsigned IDX_BASE = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ld_state_e;
endpackage

// File: rtl/dll_pick.sv
// Lowest-set-bit selector: picks the next descriptor entry still pending.
module dll_pick #(
  parameter int unsigned N = 6,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign onehot_o[g] = mask_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | mask_i[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dll_regbank.sv
// Channel register set with per-register write sources and count restore.
module dll_regbank import dll_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned IW     = 3,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sw_we_i,
  input  logic [SEL_W-1:0]              sw_sel_i,
  input  logic [DATA_W-1:0]             sw_data_i,
  input  logic                          ld_we_i,
  input  logic [IW-1:0]                 ld_idx_i,
  input  logic [DATA_W-1:0]             ld_data_i,
  input  logic                          restore_i,
  input  logic                          dec_i,
  output logic [NREG-1:0][DATA_W-1:0]   regs_o
);
  logic [CNT_W-1:0] reload_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              sw_hit;
    logic              ld_hit;
    logic [DATA_W-1:0] val_q;

    assign sw_hit    = sw_we_i && (sw_sel_i == SEL_W'(g));
    assign ld_hit    = ld_we_i && (ld_idx_i == IW'(g));
    assign regs_o[g] = val_q;

    if (g == IDX_BLK) begin : g_count
      // fetch > restore > software > decrement
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
        end else if (ld_hit) begin
          val_q <= ld_data_i;
        end else if (restore_i) begin
          val_q[CNT_W-1:0] <= reload_q;
        end else if (sw_hit) begin
          val_q <= sw_data_i;
        end else if (dec_i && (val_q[CNT_W-1:0] != '0)) begin
          val_q[CNT_W-1:0] <= val_q[CNT_W-1:0] - CNT_W'(1);
        end
      end
    end else begin : g_plain
      localparam logic [DATA_W-1:0] KEEP =
        (g == IDX_LINK) ? {{(DATA_W-2){1'b1}}, 2'b00} : {DATA_W{1'b1}};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= '0;
        end else if (ld_hit) begin
          val_q <= ld_data_i & KEEP;
        end else if (sw_hit) begin
          val_q <= sw_data_i & KEEP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (ld_we_i && (ld_idx_i == IW'(IDX_BLK))) begin
      reload_q <= ld_data_i[CNT_W-1:0];
    end else if (sw_we_i && (sw_sel_i == SEL_W'(IDX_BLK))) begin
      reload_q <= sw_data_i[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/dll_ctrl.sv
// Link-phase sequencer: end-of-chain decision, word fetch loop, pulses.
module dll_ctrl import dll_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned IW     = 3,
  localparam int unsigned BASE_W = DATA_W - PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_done_i,
  input  logic [PTR_W-3:0]  ptr_w_i,
  input  logic [NREG-1:0]   flags_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [DATA_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  output logic              ld_we_o,
  output logic [IW-1:0]     ld_idx_o,
  output logic              restore_o,
  output logic              busy_o,
  output logic              desc_loaded_o,
  output logic              chan_done_o,
  output logic              link_err_o
);
  ld_state_e         state_q;
  logic [NREG-1:0]   pend_q;
  logic [DATA_W-1:0] addr_q;
  logic              loaded_q;
  logic              cdone_q;
  logic              err_q;

  logic [IW-1:0]     pick_idx;
  logic [NREG-1:0]   pick_oh;
  logic [NREG-1:0]   remain;
  logic              start;
  logic              chain_end;
  logic              rsp_ok;

  dll_pick #(.N(NREG)) u_pick (
    .mask_i   (pend_q),
    .idx_o    (pick_idx),
    .onehot_o (pick_oh)
  );

  assign chain_end = (flags_i == '0) && (ptr_w_i == '0);
  assign start     = (state_q == ST_IDLE) && xfer_done_i;
  assign remain    = pend_q & ~pick_oh;
  assign rsp_ok    = (state_q == ST_WAIT) && rsp_valid_i && !rsp_err_i;

  assign restore_o     = start && !chain_end && !flags_i[IDX_BLK];
  assign ld_we_o       = rsp_ok;
  assign ld_idx_o      = pick_idx;
  assign req_valid_o   = (state_q == ST_REQ);
  assign req_addr_o    = addr_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign desc_loaded_o = loaded_q;
  assign chan_done_o   = cdone_q;
  assign link_err_o    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pend_q   <= '0;
      addr_q   <= '0;
      loaded_q <= 1'b0;
      cdone_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      loaded_q <= 1'b0;
      cdone_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (xfer_done_i) begin
            if (chain_end) begin
              cdone_q <= 1'b1;
            end else if (flags_i == '0) begin
              loaded_q <= 1'b1;
            end else begin
              pend_q  <= flags_i;
              addr_q  <= {base_i, ptr_w_i, 2'b00};
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            if (rsp_err_i) begin
              err_q   <= 1'b1;
              pend_q  <= '0;
              state_q <= ST_IDLE;
            end else begin
              pend_q <= remain;
              addr_q <= addr_q + DATA_W'(4);
              if (remain == '0) begin
                loaded_q <= 1'b1;
                state_q  <= ST_IDLE;
              end else begin
                state_q <= ST_REQ;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_link_loader.sv
// Top: channel register set plus link-phase sequencer.
module dma_link_loader import dll_pkg::*; #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PTR_W    = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned FLAG_LSB = 16,
  localparam int unsigned SEL_W  = $clog2(NREG + 1),
  localparam int unsigned IW     = $clog2(NREG),
  localparam int unsigned BASE_W = DATA_W - PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en_i,
  input  logic [SEL_W-1:0]  sw_wr_sel_i,
  input  logic [DATA_W-1:0] sw_wr_data_i,
  input  logic              xfer_done_i,
  input  logic              blk_dec_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [DATA_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  input  logic              rd_rsp_err_i,
  output logic [DATA_W-1:0] cfg1_o,
  output logic [DATA_W-1:0] cfg2_o,
  output logic [DATA_W-1:0] blk_o,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] dst_o,
  output logic [DATA_W-1:0] link_o,
  output logic              busy_o,
  output logic              desc_loaded_o,
  output logic              chan_done_o,
  output logic              link_err_o
);
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [BASE_W-1:0]           base_q;
  logic                        ld_we;
  logic [IW-1:0]               ld_idx;
  logic                        restore;
  logic                        busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (sw_wr_en_i && (sw_wr_sel_i == SEL_W'(IDX_BASE))) begin
      base_q <= sw_wr_data_i[BASE_W-1:0];
    end
  end

  dll_regbank #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .IW     (IW),
    .SEL_W  (SEL_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we_i   (sw_wr_en_i),
    .sw_sel_i  (sw_wr_sel_i),
    .sw_data_i (sw_wr_data_i),
    .ld_we_i   (ld_we),
    .ld_idx_i  (ld_idx),
    .ld_data_i (rd_rsp_data_i),
    .restore_i (restore),
    .dec_i     (blk_dec_i && !busy),
    .regs_o    (regs)
  );

  dll_ctrl #(
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W),
    .IW     (IW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_done_i   (xfer_done_i),
    .ptr_w_i       (regs[IDX_LINK][PTR_W-1:2]),
    .flags_i       (regs[IDX_LINK][FLAG_LSB +: NREG]),
    .base_i        (base_q),
    .req_valid_o   (rd_req_valid_o),
    .req_ready_i   (rd_req_ready_i),
    .req_addr_o    (rd_req_addr_o),
    .rsp_valid_i   (rd_rsp_valid_i),
    .rsp_err_i     (rd_rsp_err_i),
    .ld_we_o       (ld_we),
    .ld_idx_o      (ld_idx),
    .restore_o     (restore),
    .busy_o        (busy),
    .desc_loaded_o (desc_loaded_o),
    .chan_done_o   (chan_done_o),
    .link_err_o    (link_err_o)
  );

  assign busy_o = busy;
  assign cfg1_o = regs[IDX_CFG1];
  assign cfg2_o = regs[IDX_CFG2];
  assign blk_o  = regs[IDX_BLK];
  assign src_o  = regs[IDX_SRC];
  assign dst_o  = regs[IDX_DST];
  assign link_o = regs[IDX_LINK];
endmodule

// File: rtl/dll_checks.sv
module dll_checks #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_valid_o,
  input logic              rd_req_ready_i,
  input logic [DATA_W-1:0] rd_req_addr_o,
  input logic [DATA_W-1:0] link_o,
  input logic              busy_o,
  input logic              desc_loaded_o,
  input logic              chan_done_o,
  input logic              link_err_o
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));

  assert_req_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o |-> (rd_req_addr_o[1:0] == 2'b00));

  assert_link_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (link_o[1:0] == 2'b00));

  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_loaded_o && chan_done_o));

  assert_loaded_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_loaded_o |-> (!busy_o && !rd_req_valid_o));

  assert_done_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chan_done_o |-> (!busy_o && !rd_req_valid_o));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_err_o |=> link_err_o);
endmodule

bind dma_link_loader dll_checks #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_req_valid_o (rd_req_valid_o),
  .rd_req_ready_i (rd_req_ready_i),
  .rd_req_addr_o  (rd_req_addr_o),
  .link_o         (link_o),
  .busy_o         (busy_o),
  .desc_loaded_o  (desc_loaded_o),
  .chan_done_o    (chan_done_o),
  .link_err_o     (link_err_o)
);

// File: tb/dma_link_loader_tb_top.sv
`timescale 1ns/1ps
module dma_link_loader_tb_top;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en_i = 1'b0;
  logic [2:0]  sw_wr_sel_i = '0;
  logic [31:0] sw_wr_data_i = '0;
  logic        xfer_done_i = 1'b0;
  logic        blk_dec_i = 1'b0;
  logic        rd_req_valid_o;
  logic        rd_req_ready_i = 1'b0;
  logic [31:0] rd_req_addr_o;
  logic        rd_rsp_valid_i = 1'b0;
  logic [31:0] rd_rsp_data_i = '0;
  logic        rd_rsp_err_i = 1'b0;
  logic [31:0] cfg1_o, cfg2_o, blk_o, src_o, dst_o, link_o;
  logic        busy_o, desc_loaded_o, chan_done_o, link_err_o;

  always #(CLK_P/2) clk = ~clk;

  dma_link_loader dut_i (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en_i(sw_wr_en_i), .sw_wr_sel_i(sw_wr_sel_i), .sw_wr_data_i(sw_wr_data_i),
    .xfer_done_i(xfer_done_i), .blk_dec_i(blk_dec_i),
    .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
    .rd_req_addr_o(rd_req_addr_o),
    .rd_rsp_valid_i(rd_rsp_valid_i), .rd_rsp_data_i(rd_rsp_data_i),
    .rd_rsp_err_i(rd_rsp_err_i),
    .cfg1_o(cfg1_o), .cfg2_o(cfg2_o), .blk_o(blk_o), .src_o(src_o),
    .dst_o(dst_o), .link_o(link_o), .busy_o(busy_o),
    .desc_loaded_o(desc_loaded_o), .chan_done_o(chan_done_o),
    .link_err_o(link_err_o)
  );

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned n_loaded = 0;
  int unsigned n_cdone = 0;
  int unsigned req_seen = 0;
  int unsigned bp_left = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] exp_q[$];
  logic [31:0] mem [logic [31:0]];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'hDEAD_BEEF;
  endfunction

  // Driver side of the scoreboard: expected fetch addresses in order.
  task automatic expect_fetch(input logic [31:0] a);
    exp_q.push_back(a);
  endtask

  // Memory responder and scoreboard monitor, all on falling edges.
  initial begin
    bit          acc_pend = 1'b0;
    logic [31:0] acc_addr = '0;
    bit          stall_seen = 1'b0;
    logic [31:0] stall_addr = '0;
    forever begin
      @(negedge clk);
      rd_rsp_valid_i = 1'b0;
      rd_rsp_err_i   = 1'b0;
      if (acc_pend) begin
        rd_rsp_valid_i = 1'b1;
        rd_rsp_data_i  = memrd(acc_addr);
        rd_rsp_err_i   = (acc_addr == err_addr);
        acc_pend       = 1'b0;
      end
      if (rd_req_valid_o) begin
        if (bp_left > 0) begin
          rd_req_ready_i = 1'b0;
          bp_left--;
          if (stall_seen) check("R12 held address", rd_req_addr_o, stall_addr);
          else begin stall_seen = 1'b1; stall_addr = rd_req_addr_o; end
        end else begin
          rd_req_ready_i = 1'b1;
          acc_pend   = 1'b1;
          acc_addr   = rd_req_addr_o;
          stall_seen = 1'b0;
          req_seen++;
          if (exp_q.size() == 0) check("R4 unexpected request", rd_req_addr_o, 32'hFFFF_FFFF);
          else check("R4 fetch address", rd_req_addr_o, exp_q.pop_front());
        end
      end else begin
        rd_req_ready_i = 1'b0;
      end
    end
  end

  // Pulse counters, sampled a quarter period after the rising edge.
  initial forever begin
    @(posedge clk); #5;
    if (desc_loaded_o) n_loaded++;
    if (chan_done_o)   n_cdone++;
  end

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    sw_wr_en_i = 1'b1; sw_wr_sel_i = sel; sw_wr_data_i = d;
    @(negedge clk);
    sw_wr_en_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done_i = 1'b1;
    @(negedge clk); xfer_done_i = 1'b0;
  endtask

  task automatic pulse_dec();
    @(negedge clk); blk_dec_i = 1'b1;
    @(negedge clk); blk_dec_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int unsigned l0, r0, c0;
    mem[32'h2000_0100] = 32'h1111_0001;
    mem[32'h2000_0104] = 32'h2222_0002;
    mem[32'h2000_0108] = 32'hABCD_0020;
    mem[32'h2000_010C] = 32'h3000_0000;
    mem[32'h2000_0110] = 32'h4000_0000;
    mem[32'h2000_0114] = 32'h0012_0203; // flags cfg2|dst, pointer 0x200, low bits set
    mem[32'h2000_0200] = 32'h2222_BBBB;
    mem[32'h2000_0204] = 32'h4000_8000;
    mem[32'h2000_0500] = 32'h1111_5555;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, busy_o}, 32'd0);
    check("R1 request", {31'd0, rd_req_valid_o}, 32'd0);
    check("R1 error flag", {31'd0, link_err_o}, 32'd0);
    check("R1 config 1", cfg1_o, 32'd0);
    check("R1 link", link_o, 32'd0);

    sw_write(3'd0, 32'h0C0F_0001);
    sw_write(3'd1, 32'h0C0F_0002);
    sw_write(3'd2, 32'h0000_0010);
    sw_write(3'd3, 32'h1000_0000);
    sw_write(3'd4, 32'h1800_0000);
    sw_write(3'd6, 32'h0000_2000);
    sw_write(3'd5, 32'h0000_0013);
    check("R2 link low bits", link_o, 32'h0000_0010);

    // R13 decrement while idle
    pulse_dec(); pulse_dec();
    check("R13 count decrement", blk_o, 32'h0000_000E);

    // R3 end of chain, R6 no restore at end
    sw_write(3'd5, 32'h0000_0000);
    c0 = n_cdone; r0 = req_seen;
    pulse_done();
    check("R3 chan_done pulse", {31'd0, chan_done_o}, 32'd1);
    @(negedge clk);
    check("R3 chan_done one cycle", {31'd0, chan_done_o}, 32'd0);
    check("R3 no request", req_seen, r0);
    check("R3 config untouched", cfg1_o, 32'h0C0F_0001);
    check("R6 count kept at end", blk_o, 32'h0000_000E);

    // R4/R5/R10/R12 full descriptor with back-pressure
    sw_write(3'd5, 32'h003F_0100);
    l0 = n_loaded; r0 = req_seen;
    for (int i = 0; i < 6; i++) expect_fetch(32'h2000_0100 + 32'(4 * i));
    bp_left = 3;
    pulse_done();
    wait_idle();
    check("R5 config 1", cfg1_o, 32'h1111_0001);
    check("R5 config 2", cfg2_o, 32'h2222_0002);
    check("R5 block", blk_o, 32'hABCD_0020);
    check("R5 source", src_o, 32'h3000_0000);
    check("R5 destination", dst_o, 32'h4000_0000);
    check("R2 fetched link", link_o, 32'h0012_0200);
    check("R4 word count", req_seen - r0, 32'd6);
    check("R10 loaded pulse", n_loaded - l0, 32'd1);

    // R6 restore before fetch, R8 fetched link governs this phase
    pulse_dec();
    check("R13 count decrement 2", blk_o, 32'hABCD_001F);
    r0 = req_seen;
    expect_fetch(32'h2000_0200);
    expect_fetch(32'h2000_0204);
    pulse_done();
    check("R6 restore", blk_o, 32'hABCD_0020);
    wait_idle();
    check("R8 words fetched", req_seen - r0, 32'd2);
    check("R5 config 2 reloaded", cfg2_o, 32'h2222_BBBB);
    check("R5 destination reloaded", dst_o, 32'h4000_8000);
    check("R5 source kept", src_o, 32'h3000_0000);
    check("R5 config 1 kept", cfg1_o, 32'h1111_0001);

    // R7 restore beats decrement in the same cycle; R10 no-fetch load
    sw_write(3'd5, 32'h0000_0400);
    pulse_dec();
    check("R13 count decrement 3", blk_o, 32'hABCD_001F);
    r0 = req_seen;
    @(negedge clk); xfer_done_i = 1'b1; blk_dec_i = 1'b1;
    @(negedge clk); xfer_done_i = 1'b0; blk_dec_i = 1'b0;
    check("R7 restore wins", blk_o, 32'hABCD_0020);
    check("R10 loaded without fetch", {31'd0, desc_loaded_o}, 32'd1);
    @(negedge clk);
    check("R10 no fetch", req_seen, r0);

    // R11 second done while busy is ignored
    sw_write(3'd5, 32'h0001_0500);
    l0 = n_loaded; r0 = req_seen;
    expect_fetch(32'h2000_0500);
    bp_left = 4;
    pulse_done();
    pulse_done();
    wait_idle();
    check("R11 single fetch", req_seen - r0, 32'd1);
    check("R11 single load", n_loaded - l0, 32'd1);
    check("R5 config 1 fetched", cfg1_o, 32'h1111_5555);

    // R9 error aborts the phase
    sw_write(3'd5, 32'h0003_0600);
    err_addr = 32'h2000_0600;
    l0 = n_loaded; r0 = req_seen;
    expect_fetch(32'h2000_0600);
    pulse_done();
    wait_idle();
    check("R9 error flag", {31'd0, link_err_o}, 32'd1);
    check("R9 one request only", req_seen - r0, 32'd1);
    check("R9 no load pulse", n_loaded - l0, 32'd0);
    check("R9 config 1 kept", cfg1_o, 32'h1111_5555);
    check("R9 config 2 kept", cfg2_o, 32'h2222_BBBB);
    repeat (5) @(negedge clk);
    check("R9 flag sticky", {31'd0, link_err_o}, 32'd1);
    check("R4 scoreboard drained", exp_q.size(), 32'd0);

    summary();
    $finish;
  end
endmodule